// File: doc/BRIEF.md
# Status-Change Delta Register Bank

This block watches eight live status levels coming from a line or framing monitor and keeps one sticky flag per level. A flag goes to 1 whenever its status level changes, on a rise or a fall, and stays at 1 until software clears it. Software can therefore find out that a condition came and went, even when the level is back where it started by the time it looks.

Software reaches the flags through a small synchronous register port that has an address, a read strobe, a write strobe, write data and registered read data. A bank-wide mode input sets how the flags are cleared. In clear-on-read mode, reading the flag register returns the flags and clears them. In clear-on-write mode, software writes 1s to the flags it wants to clear. One flag position, the C-bit detect change, is always cleared by a read, whichever mode is selected. The same port also returns a fixed identification value and a version number.

Top module: `stat_delta_bank`

## Requirements
- R1: A change of `stat_in[i]` in either direction sets flag i. When the input changes between clock edges, the flag is set at the second rising edge after the change.
- R2: After a flag is cleared, it stays at 0 until its input changes again. Levels that are held while reset is asserted count as the baseline and produce no event.
- R3: With `clr_mode`=0 (clear-on-read), a read strobe to address 2 loads the flags as they were before the clear into `bus_rdata`[7:0] at that edge. All flags are cleared at the same edge.
- R4: With `clr_mode`=1 (clear-on-write), a write strobe to address 2 clears every flag whose `bus_wdata` bit is 1 and leaves the other flags unchanged. A read does not clear these flags.
- R5: Flag 4 is cleared by any read of address 2 in either mode, and no write ever clears it. With `clr_mode`=0, writes have no effect on any flag.
- R6: When a new status change and a clear act on the same flag at the same edge, the flag ends at 1.
- R7: Flag i of register address 2 sits at bit i of `bus_rdata`. Bits 15:8 always read as 0.
- R8: A read of address 0 returns 0x0001. A read of address 1 returns the 3-bit version (default 2) in bits 2:0, with the other bits at 0. A read of any other address returns 0.
- R9: After reset, all flags and `bus_rdata` are 0. `bus_rdata` changes only at an edge where a read strobe is present.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| stat_in | input | 8 | Live status levels, one per flag |
| clr_mode | input | 1 | 0 selects clear-on-read, 1 selects clear-on-write |
| bus_addr | input | 4 | Register address |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 8 | Write data; a 1 marks a flag to clear |
| bus_rdata | output | 16 | Registered read data |

## Verification
The two things that can land on the same edge are a clear of a flag (a read in clear-on-read mode, or a write of 1 in clear-on-write mode) and the set event from a new status change on that flag. The bench produces this overlap by toggling a status input one cycle before it issues the strobe, so the change pulse reaches the flag at the same edge as the clear. It then checks two things: the strobed read returns the value from before the set, and a second read still shows the flag at 1.

// File: rtl/sdb_pkg.sv
// Package: shared constants and types for the status-change delta bank.
// Assumes: register addresses fit the bus address width chosen at the top.
package sdb_pkg;

    localparam int SDB_ADDR_ID    = 0;
    localparam int SDB_ADDR_VER   = 1;
    localparam int SDB_ADDR_DELTA = 2;

    typedef enum logic {
        CLR_ON_READ  = 1'b0,
        CLR_ON_WRITE = 1'b1
    } clr_mode_e;

endpackage

// File: rtl/sdb_edge_detect.sv
// Module: samples the status levels once and compares each sample with the
// previous one, giving a one-cycle change pulse for every level transition.
// Assumes: inputs are already synchronous to clk. During reset both stages
// load the live level, so whatever is held in reset is taken as the baseline.
module sdb_edge_detect #(
    parameter int NUM_BITS = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_BITS-1:0] stat_i,
    output logic [NUM_BITS-1:0] chg_o
);

    logic [NUM_BITS-1:0] samp_q;
    logic [NUM_BITS-1:0] prev_q;

    // Purpose: two-stage history of the status levels, seeded in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            samp_q <= stat_i;
            prev_q <= stat_i;
        end else begin
            samp_q <= stat_i;
            prev_q <= samp_q;
        end
    end

    // Purpose: flag positions whose sampled level differs from the one before.
    always_comb begin
        chg_o = samp_q ^ prev_q;
    end

    AST_CHG_TRACKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n) $past(rst_n) && (samp_q != stat_i) |=> (chg_o != '0)); // R1

endmodule

// File: rtl/sdb_delta_cell.sv
// Module: one sticky change flag with its clear policy. Setting has priority
// over clearing, so no change event is ever lost.
// Assumes: rd_hit_i and wr_hit_i are already decoded for the flag register.
// FORCE_COR=1 selects the variant that only a read can clear.
module sdb_delta_cell
    import sdb_pkg::*;
#(
    parameter bit FORCE_COR = 1'b0
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      chg_i,
    input  clr_mode_e mode_i,
    input  logic      rd_hit_i,
    input  logic      wr_hit_i,
    input  logic      wbit_i,
    output logic      bit_o
);

    localparam bit WRITE_CLEARABLE = !FORCE_COR;

    logic clr_rd;
    logic clr_wr;
    logic bit_d;

    // Purpose: work out which clear sources apply to this flag.
    always_comb begin
        clr_rd = rd_hit_i && (FORCE_COR || (mode_i == CLR_ON_READ));
        clr_wr = WRITE_CLEARABLE && wr_hit_i && wbit_i && (mode_i == CLR_ON_WRITE);
        bit_d  = chg_i || (bit_o && !(clr_rd || clr_wr));
    end

    // Purpose: hold the sticky flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_o <= 1'b0;
        end else begin
            bit_o <= bit_d;
        end
    end

    AST_SET_WINS:        assert property (@(posedge clk) disable iff (!rst_n) chg_i |=> bit_o); // R6
    AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_n) !chg_i && !bit_o |=> !bit_o); // R2
    AST_READ_CLEARS:     assert property (@(posedge clk) disable iff (!rst_n) rd_hit_i && (FORCE_COR || mode_i == CLR_ON_READ) && !chg_i |=> !bit_o); // R3
    AST_COW_READ_KEEPS:  assert property (@(posedge clk) disable iff (!rst_n) bit_o && !FORCE_COR && mode_i == CLR_ON_WRITE && !(wr_hit_i && wbit_i) |=> bit_o); // R4

    generate
        if (FORCE_COR) begin : g_forced_chk
            AST_FORCED_IGNORES_WRITE: assert property (@(posedge clk) disable iff (!rst_n) bit_o && wr_hit_i && !rd_hit_i |=> bit_o); // R5
        end else begin : g_mode_chk
            AST_COR_IGNORES_WRITE: assert property (@(posedge clk) disable iff (!rst_n) bit_o && wr_hit_i && !rd_hit_i && mode_i == CLR_ON_READ |=> bit_o); // R5
        end
    endgenerate

endmodule

// File: rtl/sdb_read_mux.sv
// Module: selects the addressed register and registers it onto the read data
// bus at the edge where the read strobe is present.
// Assumes: one-cycle read strobes; unmapped addresses read as zero.
module sdb_read_mux
    import sdb_pkg::*;
#(
    parameter int          NUM_BITS  = 8,
    parameter int          DATA_W    = 16,
    parameter int          ADDR_W    = 4,
    parameter int          VER_W     = 3,
    parameter logic [7:0]  ID_VALUE  = 8'h01,
    parameter logic [VER_W-1:0] VER_VALUE = 3'd2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rd_i,
    input  logic [ADDR_W-1:0]   addr_i,
    input  logic [NUM_BITS-1:0] delta_i,
    output logic [DATA_W-1:0]   rdata_o
);

    logic [DATA_W-1:0] sel_d;

    // Purpose: address decode of the three readable registers.
    always_comb begin
        sel_d = '0;
        if (addr_i == ADDR_W'(SDB_ADDR_ID)) begin
            sel_d[7:0] = ID_VALUE;
        end else if (addr_i == ADDR_W'(SDB_ADDR_VER)) begin
            sel_d[VER_W-1:0] = VER_VALUE;
        end else if (addr_i == ADDR_W'(SDB_ADDR_DELTA)) begin
            sel_d[NUM_BITS-1:0] = delta_i;
        end
    end

    // Purpose: capture read data only on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_o <= '0;
        end else if (rd_i) begin
            rdata_o <= sel_d;
        end
    end

    AST_RDATA_HOLDS:  assert property (@(posedge clk) disable iff (!rst_n) !rd_i |=> $stable(rdata_o)); // R9
    AST_ID_VALUE:     assert property (@(posedge clk) disable iff (!rst_n) rd_i && addr_i == ADDR_W'(SDB_ADDR_ID) |=> rdata_o == DATA_W'(ID_VALUE)); // R8
    AST_DELTA_RETURN: assert property (@(posedge clk) disable iff (!rst_n) rd_i && addr_i == ADDR_W'(SDB_ADDR_DELTA) |=> rdata_o == DATA_W'($past(delta_i))); // R3

endmodule

// File: rtl/stat_delta_bank.sv
// Module: top of the status-change delta bank. Detects level changes on the
// status inputs, keeps one sticky flag per input, and serves the flag, ID
// and version registers on a simple synchronous register port.
// Assumes: single-cycle strobes, status inputs synchronous to clk, and
// clr_mode held steady while software is clearing flags.
module stat_delta_bank
    import sdb_pkg::*;
#(
    parameter int         NUM_BITS   = 8,
    parameter int         DATA_W     = 16,
    parameter int         ADDR_W     = 4,
    parameter int         VER_W      = 3,
    parameter int         FORCED_BIT = 4,
    parameter logic [7:0] ID_VALUE   = 8'h01,
    parameter logic [VER_W-1:0] VER_VALUE = 3'd2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_BITS-1:0] stat_in,
    input  logic                clr_mode,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_rd,
    input  logic                bus_wr,
    input  logic [NUM_BITS-1:0] bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata
);

    logic [NUM_BITS-1:0] chg;
    logic [NUM_BITS-1:0] delta;
    logic                rd_hit;
    logic                wr_hit;
    clr_mode_e           mode;

    // Purpose: decode strobes aimed at the flag register and type the mode.
    always_comb begin
        rd_hit = bus_rd && (bus_addr == ADDR_W'(SDB_ADDR_DELTA));
        wr_hit = bus_wr && (bus_addr == ADDR_W'(SDB_ADDR_DELTA));
        mode   = clr_mode_e'(clr_mode);
    end

    sdb_edge_detect #(
        .NUM_BITS (NUM_BITS)
    ) edge_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .stat_i (stat_in),
        .chg_o  (chg)
    );

    generate
        for (genvar gi = 0; gi < NUM_BITS; gi++) begin : g_cell
            sdb_delta_cell #(
                .FORCE_COR (gi == FORCED_BIT)
            ) cell_i (
                .clk      (clk),
                .rst_n    (rst_n),
                .chg_i    (chg[gi]),
                .mode_i   (mode),
                .rd_hit_i (rd_hit),
                .wr_hit_i (wr_hit),
                .wbit_i   (bus_wdata[gi]),
                .bit_o    (delta[gi])
            );
        end
    endgenerate

    sdb_read_mux #(
        .NUM_BITS  (NUM_BITS),
        .DATA_W    (DATA_W),
        .ADDR_W    (ADDR_W),
        .VER_W     (VER_W),
        .ID_VALUE  (ID_VALUE),
        .VER_VALUE (VER_VALUE)
    ) mux_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_i    (bus_rd),
        .addr_i  (bus_addr),
        .delta_i (delta),
        .rdata_o (bus_rdata)
    );

    AST_RSVD_ZERO:     assert property (@(posedge clk) disable iff (!rst_n) $past(bus_rd) |-> bus_rdata[DATA_W-1:NUM_BITS] == '0); // R7
    AST_CHANGE_SETS:   assert property (@(posedge clk) disable iff (!rst_n) chg != '0 |=> (delta & $past(chg)) == $past(chg)); // R1

endmodule

// File: tb/stat_delta_bank_tb_top.sv
module stat_delta_bank_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 12;

    typedef struct packed {
        logic        mode;
        logic        is_wr;
        logic [7:0]  mask;
        logic [7:0]  wdata;
        logic [15:0] exp;
    } vec_t;

    // mode, is_wr, toggle mask, write data, expected read data
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 1'b0, 8'h01, 8'h00, 16'h0001},
        '{1'b0, 1'b0, 8'h00, 8'h00, 16'h0000},
        '{1'b0, 1'b0, 8'h01, 8'h00, 16'h0001},
        '{1'b0, 1'b0, 8'hA5, 8'h00, 16'h00A5},
        '{1'b0, 1'b1, 8'h5A, 8'hFF, 16'h0000},
        '{1'b0, 1'b0, 8'h00, 8'h00, 16'h005A},
        '{1'b1, 1'b1, 8'hFF, 8'h0F, 16'h0000},
        '{1'b1, 1'b0, 8'h00, 8'h00, 16'h00F0},
        '{1'b1, 1'b0, 8'h00, 8'h00, 16'h00E0},
        '{1'b1, 1'b1, 8'h10, 8'hF0, 16'h0000},
        '{1'b1, 1'b0, 8'h00, 8'h00, 16'h0010},
        '{1'b1, 1'b0, 8'h00, 8'h00, 16'h0000}
    };
    // rise R1, cleared R3, fall R1, layout R7, COR write R5, COW read R4, bit 4 R5, idle R2
    localparam string TAGS [NVEC] = '{"R1", "R3", "R1", "R7", "-", "R5",
                                      "-", "R4", "R5", "-", "R5", "R2"};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  stat_in = '0;
    logic        clr_mode = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [15:0] bus_rdata;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    stat_delta_bank dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .stat_in   (stat_in),
        .clr_mode  (clr_mode),
        .bus_addr  (bus_addr),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%04h expected 0x%04h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk) rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic toggle(input logic [7:0] m);
        if (m != 8'h00) begin
            @(negedge clk) stat_in = stat_in ^ m;
            repeat (2) @(negedge clk);
        end
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_addr = a;
        bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic bus_write(input logic [7:0] w);
        @(negedge clk);
        bus_addr = 4'd2;
        bus_wdata = w;
        bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    initial begin
        logic [15:0] d;
        do_reset();
        @(negedge clk);
        check("R9 rdata after reset", bus_rdata, 16'h0000);
        bus_read(4'd2, d);
        check("R9 flags after reset", d, 16'h0000);
        bus_read(4'd0, d);
        check("R8 id", d, 16'h0001);
        bus_read(4'd1, d);
        check("R8 version", d, 16'h0002);
        bus_read(4'd7, d);
        check("R8 unmapped", d, 16'h0000);

        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk) clr_mode = VECS[i].mode;
            toggle(VECS[i].mask);
            if (VECS[i].is_wr) begin
                bus_write(VECS[i].wdata);
            end else begin
                bus_read(4'd2, d);
                check(TAGS[i], d, VECS[i].exp);
            end
        end

        // R6 clear-on-read meets a new change at the same edge
        @(negedge clk) clr_mode = 1'b0;
        @(negedge clk) stat_in = stat_in ^ 8'h04;
        @(negedge clk);
        bus_addr = 4'd2;
        bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        check("R6 COR pre-set read", bus_rdata, 16'h0000);
        bus_read(4'd2, d);
        check("R6 COR set survives", d, 16'h0004);

        // R6 clear-on-write meets a new change at the same edge
        @(negedge clk) clr_mode = 1'b1;
        @(negedge clk) stat_in = stat_in ^ 8'h01;
        @(negedge clk);
        bus_addr = 4'd2;
        bus_wdata = 8'h01;
        bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        bus_read(4'd2, d);
        check("R6 COW set survives", d, 16'h0001);
        bus_write(8'h01);
        bus_read(4'd2, d);
        check("R4 COW write clears", d, 16'h0000);

        // R2 levels held through reset are the baseline
        @(negedge clk) stat_in = 8'h3C;
        do_reset();
        repeat (3) @(negedge clk);
        bus_read(4'd2, d);
        check("R2 no event from reset levels", d, 16'h0000);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule